// File: doc/BRIEF.md
# Supervisory Watchdog and Longdog Timer Pair

This block holds two supervisory timers that are fed by one shared tick pulse and restarted by a single asynchronous kick strobe. The short-period timer (watchdog) and the long-period timer (longdog) each count tick pulses up to their own 16-bit limit. When a limit is reached, the matching active-low alarm output drops. Software or a host processor shows it is alive by making rising edges on the kick input. The block's tick source, the reset generator and any configuration registers sit outside. The block only receives a tick strobe, a flag that says the reset outputs are active, and the two limits.

While the supervisor's reset outputs are active, both timers are frozen at zero and their alarms are high. The instant of release is time zero for both. If the kick input is held high, the watchdog is switched off. The longdog then becomes a free-running square wave whose low and high halves each last one longdog period.

Top module: `wdog_pair`

## Requirements
- R1: While `sup_rst_act` is 1, both alarm outputs read 1 from the next clock edge on, and ticks have no effect. After release, counting starts from zero.
- R2: With the kick input low, `wd_alarm_n` goes to 0 on the clock edge that samples the `wd_limit`-th tick after time zero. It stays 0 until the next kick rising edge or reset.
- R3: The longdog works the same way with `ld_alarm_n` and `ld_limit`, independently of the watchdog limit.
- R4: A rising edge on the kick input restarts both timers. Both alarms return to 1 and both counts restart from zero.
- R5: While the kick input is held high, `wd_alarm_n` stays 1. `ld_alarm_n` starts at 1 and toggles each time `ld_limit` ticks have passed, so the low and high phases are equal.
- R6: A limit value of 0 disables that timer, and its alarm stays at 1.
- R7: Asserting `sup_rst_act` in the middle of a run clears both timers, whatever their state.
- R8: A tick that arrives in the same cycle as the restart caused by a kick edge is discarded.
- R9: The kick input passes through two synchronizer flops. The restart takes effect on the third rising clock edge after the input rises. Before that edge, the alarms keep their prior values.
- R10: Outside reset and restart, an alarm output changes only on a cycle where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sup_rst_act | input | 1 | 1 while the supervisor's reset outputs are asserted |
| tick | input | 1 | One-cycle timebase pulse shared by both timers |
| kick_async | input | 1 | Asynchronous kick strobe; rising edges restart, level high selects pulse mode |
| wd_limit | input | 16 | Watchdog period in ticks; 0 disables |
| ld_limit | input | 16 | Longdog period in ticks; 0 disables |
| wd_alarm_n | output | 1 | Active-low watchdog timeout |
| ld_alarm_n | output | 1 | Active-low longdog timeout / square wave |

## Verification
A kick restart and a counting tick can land in the same clock cycle. The same applies to a restart and the tick that would complete a longdog period. The bench provokes this by raising the kick input so that its synchronized edge meets a tick on the third clock. It uses a longdog limit of 1, where a counted tick would pull the alarm low at once. It then checks that both alarms read high and that the next period is a full one. Every limit pair from 0 to 4 is swept, and the expected alarm levels come from the bench's own tick count, compared against the limits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Behaviour of a timer when its period elapses.
  typedef enum logic {
    TMR_ONESHOT = 1'b0,  // latch low until restart
    TMR_TOGGLE  = 1'b1   // flip output while kick is held high
  } tmr_mode_e;

  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  output logic kick_hi,
  output logic kick_rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              kick_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= kick_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_prev <= 1'b0;
    else        kick_prev <= chain[LAST];
  end

  assign kick_hi   = chain[LAST];
  assign kick_rise = chain[LAST] & ~kick_prev;

  // R9: the synchronized edge is a single-cycle event
  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_rise |=> !kick_rise);
endmodule

// File: rtl/wdog_tmr_core.sv
module wdog_tmr_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter tmr_mode_e   MODE  = TMR_ONESHOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_hold,
  input  logic             restart,
  input  logic             tick,
  input  logic             kick_hi,
  input  logic [CNT_W-1:0] limit,
  output logic             alarm_n,
  output logic             expire
);
  localparam int unsigned EXT_W = CNT_W + 1;

  // True when one more tick reaches (or passes) the limit.
  function automatic logic at_limit(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] lim);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, c} + EXT_W'(1);
    return nxt >= {1'b0, lim};
  endfunction

  // Alarm level that follows an elapsed period.
  function automatic logic after_expire(input logic cur, input logic held);
    if (MODE == TMR_TOGGLE && held) return ~cur;
    return 1'b0;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             alarm_q;
  logic             halt;
  logic             mode_clr;
  logic             run;

  assign halt = sys_hold | ~|limit;

  generate
    if (MODE == TMR_TOGGLE) begin : g_toggle
      assign mode_clr = 1'b0;
      assign run      = tick & (kick_hi | alarm_q);
    end else begin : g_oneshot
      assign mode_clr = kick_hi;
      assign run      = tick & ~kick_hi & alarm_q;
    end
  endgenerate

  assign expire = run & at_limit(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      alarm_q <= 1'b1;
    end else if (halt | restart | mode_clr) begin
      cnt     <= '0;
      alarm_q <= 1'b1;
    end else if (expire) begin
      cnt     <= '0;
      alarm_q <= after_expire(alarm_q, kick_hi);
    end else if (run) begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  assign alarm_n = alarm_q;

  // R1 / R6 / R7: a held timer is cleared
  p_hold_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (alarm_n && cnt == '0));
  // R4: restart releases the alarm
  p_restart_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> alarm_n);
  // R10: no alarm movement without a tick
  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !restart && !tick) |=> $stable(alarm_n));
  // R8: tick colliding with restart is not counted
  p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && tick && !halt) |=> (cnt == '0));

  generate
    if (MODE == TMR_ONESHOT) begin : g_chk_latch
      // R2: a timed-out watchdog stays low until restart or hold
      p_latch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && !halt && !restart && !kick_hi) |=> !alarm_n);
    end
  endgenerate
endmodule

// File: rtl/wdog_pair.sv
module wdog_pair
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_rst_act,
  input  logic             tick,
  input  logic             kick_async,
  input  logic [CNT_W-1:0] wd_limit,
  input  logic [CNT_W-1:0] ld_limit,
  output logic             wd_alarm_n,
  output logic             ld_alarm_n
);
  logic kick_hi;
  logic kick_rise;
  logic wd_expire;
  logic ld_expire;

  wdog_kick_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_async(kick_async),
    .kick_hi   (kick_hi),
    .kick_rise (kick_rise)
  );

  wdog_tmr_core #(.CNT_W(CNT_W), .MODE(TMR_ONESHOT)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_hold(sup_rst_act),
    .restart (kick_rise),
    .tick    (tick),
    .kick_hi (kick_hi),
    .limit   (wd_limit),
    .alarm_n (wd_alarm_n),
    .expire  (wd_expire)
  );

  wdog_tmr_core #(.CNT_W(CNT_W), .MODE(TMR_TOGGLE)) u_ld (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_hold(sup_rst_act),
    .restart (kick_rise),
    .tick    (tick),
    .kick_hi (kick_hi),
    .limit   (ld_limit),
    .alarm_n (ld_alarm_n),
    .expire  (ld_expire)
  );

  // R5: watchdog is off while the kick level is high
  p_wd_off_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hi |=> wd_alarm_n);
  // R7: supervisor reset drives both alarms high
  p_reset_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst_act |=> (wd_alarm_n && ld_alarm_n));
  // R10: an expiry only occurs on a tick
  p_expire_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire || ld_expire) |-> tick);
endmodule

// File: tb/wdog_pair_bench.sv
module wdog_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sup_rst_act;
  logic        tick;
  logic        kick_async;
  logic [15:0] wd_limit;
  logic [15:0] ld_limit;
  logic        wd_alarm_n;
  logic        ld_alarm_n;

  int n_run  = 0;
  int n_fail = 0;
  int n_tk   = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  wdog_pair u_wdog_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_rst_act(sup_rst_act),
    .tick       (tick),
    .kick_async (kick_async),
    .wd_limit   (wd_limit),
    .ld_limit   (ld_limit),
    .wd_alarm_n (wd_alarm_n),
    .ld_alarm_n (ld_alarm_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lw=%0d ll=%0d n=%0d actual=%b expected=%b",
               tag, wd_limit, ld_limit, n_tk, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic wd_exp(input bit held);
    if (held || wd_limit == 0) return 1'b1;
    return !(n_tk >= int'(wd_limit));
  endfunction

  function automatic logic ld_exp(input bit held);
    if (ld_limit == 0) return 1'b1;
    if (held) return ((n_tk / int'(ld_limit)) % 2) == 0;
    return !(n_tk >= int'(ld_limit));
  endfunction

  task automatic chk_both(input string tag, input bit held);
    chk({tag, " wd"}, wd_alarm_n, wd_exp(held));
    chk({tag, " ld"}, ld_alarm_n, ld_exp(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sup_rst_act = 1'b1; tick = 1'b0; kick_async = 1'b0;
    wd_limit = 16'd0; ld_limit = 16'd0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int lw = 0; lw <= 4; lw++) begin
      for (int ll = 0; ll <= 4; ll++) begin
        wd_limit = 16'(lw);
        ld_limit = 16'(ll);
        // R1 / R7: supervisor reset clears any prior state, ticks ignored
        sup_rst_act = 1'b1;
        for (int i = 0; i < 3; i++) begin
          cyc(1'b1);
          chk("R1 R7 hold", wd_alarm_n, 1'b1);
          chk("R1 R7 hold", ld_alarm_n, 1'b1);
        end
        sup_rst_act = 1'b0;
        n_tk = 0;
        // R2 R3 R6 R10: count ticks with gaps, kick low
        for (int i = 0; i < 14; i++) begin
          logic t;
          t = (i % 3 != 2);
          cyc(t);
          if (t) n_tk++;
          chk_both(t ? "R2 R3 R6" : "R10 gap", 1'b0);
        end
        // R9: two edges after kick rises nothing changes
        kick_async = 1'b1;
        cyc(1'b0); chk_both("R9 sync", 1'b0);
        cyc(1'b0); chk_both("R9 sync", 1'b0);
        kick_async = 1'b0;
        cyc(1'b0);
        n_tk = 0;
        chk_both("R4 restart", 1'b0);
        cyc(1'b0);
        chk_both("R4 restart", 1'b0);
        // R4: count anew from zero after restart
        for (int i = 0; i < 8; i++) begin
          cyc(1'b1);
          n_tk++;
          chk_both("R4 recount", 1'b0);
        end
        // R8: restart edge coincides with a tick
        kick_async = 1'b1;
        cyc(1'b0);
        cyc(1'b0);
        cyc(1'b1);
        n_tk = 0;
        chk_both("R8 collide", 1'b1);
        // R5: pulse train while held high
        for (int i = 0; i < 4 * ll + 3; i++) begin
          logic t;
          t = (i % 4 != 3);
          cyc(t);
          if (t) n_tk++;
          chk_both("R5 held", 1'b1);
        end
        kick_async = 1'b0;
        cyc(1'b0); cyc(1'b0); cyc(1'b0);
        // R7: mid-run supervisor reset
        sup_rst_act = 1'b1;
        cyc(1'b0);
        chk("R7 midrun", wd_alarm_n, 1'b1);
        chk("R7 midrun", ld_alarm_n, 1'b1);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule